// File: doc/BRIEF.md
# Event-Driven DMA Address Sequencer

This block holds one transfer parameter set and turns each synchronization event into a stream of byte-level (source, destination) address pairs. The set consists of:

- a 12-bit options word;
- source and destination base addresses;
- a byte count per array (ACNT);
- an array count (BCNT);
- a signed array stride for each side.

A data mover downstream takes the pairs over a valid/ready stream, one pair per cycle. A one-cycle completion pulse marks the end of each event's work. The pulse comes either when the transfer is issued or after its last pair is accepted.

Options word layout. This field layout is decoded by the block and is fixed:

| Bits | Meaning |
|------|---------|
| 11 | Completion timing |
| 10:8 | FIFO width code |
| 7:4 | Reserved, must be zero |
| 3 | Static flag |
| 2 | Sync dimension |
| 1 | Destination address mode |
| 0 | Source address mode |

Each side can count upward through an array, or wrap inside a window the width of a FIFO. A set that is not static is written back when an event is issued. This lets a series of single-array events walk through memory until the array count runs out. An event that arrives during a transfer waits in a single pending slot. Overruns and bad option words raise sticky flags, which a new parameter load clears.

Top module: `evt_addr_seq`

## Requirements
- R1: With options bit 2 = 0, every accepted event yields exactly ACNT pairs, forming one array that starts at the stored bases.
- R2: With options bit 2 = 1, every accepted event yields BCNT arrays of ACNT pairs. Array j on each side starts at that side's base + j × that side's sign-extended stride.
- R3: A side whose mode bit is 0 (bit 0 source, bit 1 destination) emits array start + i for byte index i.
- R4: A side whose mode bit is 1 emits array start + (i mod 2^code) bytes. The code is options bits 10:8, where 0..5 give windows of 1, 2, 4, 8, 16 and 32 bytes.
- R5: An event is rejected when options bits 7:4 are non-zero, or when either side is in wrap mode with code 6 or 7. A rejected event sets the sticky `err` flag and produces no pairs, no completion pulse and no write-back. With both sides counting upward, the code is ignored.
- R6: With options bit 3 = 0, issuing a single-array event decrements BCNT and adds each stride to its base, while issuing a multi-array event sets BCNT to zero. With bit 3 = 1, the set is never changed by an event.
- R7: `exhausted` is high whenever the stored BCNT is zero, including after reset. Events are then ignored.
- R8: With options bit 11 = 0, `done` is high for one cycle, in the cycle after the handshake of the event's final pair.
- R9: With options bit 11 = 1, `done` is high for one cycle, in the first cycle that `out_valid` is high for that event.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_src` and `out_dst` hold their values.
- R11: An event that arrives during a transfer is held as pending and starts, in order, once the transfer ends. An event that arrives while one is already pending is lost and sets the sticky `missed` flag.
- R12: `cfg_load` takes effect only when no transfer is running or pending. An accepted load clears `err` and `missed`, and an event in the same cycle as an accepted load is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the parameter set from the cfg_* inputs |
| cfg_opts | input | 12 | Options word |
| cfg_src | input | AW | Source base address |
| cfg_dst | input | AW | Destination base address |
| cfg_acnt | input | CW | Bytes per array (at least 1) |
| cfg_bcnt | input | CW | Array count |
| cfg_sstride | input | SW | Signed source array stride |
| cfg_dstride | input | SW | Signed destination array stride |
| evt | input | 1 | Synchronization event, one pulse per event |
| out_valid | output | 1 | Address pair valid |
| out_ready | input | 1 | Consumer accepts the pair |
| out_src | output | AW | Source byte address |
| out_dst | output | AW | Destination byte address |
| done | output | 1 | Completion pulse |
| err | output | 1 | Sticky rejected-options flag |
| missed | output | 1 | Sticky lost-event flag |
| exhausted | output | 1 | Stored array count is zero |

## Verification
A new event can land in the same cycle as the handshake of the final pair of the running transfer. In that cycle the block is still busy, so the event must go to the pending slot without being lost and without setting `missed`. The bench provokes this by timing an event pulse onto the final beat of a two-byte transfer while `out_ready` is held high. It then judges the result from two things: the second transfer's addresses in the stream (taken from the written-back set), and `missed` staying low. A second collision, an event in the same cycle as an accepted load, is judged by the absence of any pair or completion pulse.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  // Field layout is fixed by the options word bit positions.
  typedef struct packed {
    logic       early;   // 11
    logic [2:0] fw;      // 10:8
    logic [3:0] rsv;     // 7:4
    logic       stat;    // 3
    logic       ab;      // 2
    logic       dcon;    // 1
    logic       scon;    // 0
  } opt_t;

  localparam int OPT_W = 12;
endpackage

// File: rtl/evt_seq_pset.sv
module evt_seq_pset
  import evt_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  opt_t          ld_opts,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_acnt,
  input  logic [CW-1:0] ld_bcnt,
  input  logic [SW-1:0] ld_sstr,
  input  logic [SW-1:0] ld_dstr,
  input  logic          wb_step,
  input  logic          wb_clear,
  output opt_t          opts,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] acnt,
  output logic [CW-1:0] bcnt,
  output logic [AW-1:0] sstr_x,
  output logic [AW-1:0] dstr_x
);
  localparam int EXT = AW - SW;

  logic [SW-1:0] sstr_q, dstr_q;

  assign sstr_x = {{EXT{sstr_q[SW-1]}}, sstr_q};
  assign dstr_x = {{EXT{dstr_q[SW-1]}}, dstr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      opts   <= '0;
      src    <= '0;
      dst    <= '0;
      acnt   <= '0;
      bcnt   <= '0;
      sstr_q <= '0;
      dstr_q <= '0;
    end else if (ld) begin
      opts   <= ld_opts;
      src    <= ld_src;
      dst    <= ld_dst;
      acnt   <= ld_acnt;
      bcnt   <= ld_bcnt;
      sstr_q <= ld_sstr;
      dstr_q <= ld_dstr;
    end else if (wb_step) begin
      bcnt <= bcnt - CW'(1);
      src  <= src + sstr_x;
      dst  <= dst + dstr_x;
    end else if (wb_clear) begin
      bcnt <= '0;
    end
  end
endmodule

// File: rtl/evt_seq_side.sv
module evt_seq_side #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step,
  input  logic          arr_end,
  input  logic          cmode,
  input  logic [2:0]    fwsel,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] arr;
  logic [AW-1:0] fwm;
  logic          wrap;

  assign fwm  = (AW'(1) << fwsel) - AW'(1);
  assign wrap = cmode && ((addr - arr) == fwm);

  always_ff @(posedge clk) begin
    if (rst) begin
      arr  <= '0;
      addr <= '0;
    end else if (start) begin
      arr  <= base;
      addr <= base;
    end else if (step) begin
      if (arr_end) begin
        arr  <= arr + stride;
        addr <= arr + stride;
      end else if (wrap) begin
        addr <= arr;
      end else begin
        addr <= addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic          ld_req,
  input  logic          out_ready,
  input  opt_t          opts,
  input  logic [CW-1:0] acnt,
  input  logic [CW-1:0] bcnt,
  output logic          ld_ok,
  output logic          start,
  output logic          step,
  output logic          arr_end,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          missed,
  output logic          exhausted,
  output logic          wb_step,
  output logic          wb_clear
);
  logic          pend;
  logic [CW-1:0] i_cnt, j_cnt, narr;
  logic          trig, bad, last_i, last_j;

  assign exhausted = (bcnt == '0);
  assign ld_ok     = ld_req && !busy && !pend;
  assign trig      = !busy && !ld_ok && (evt || pend);
  assign bad       = (opts.rsv != '0) ||
                     ((opts.scon || opts.dcon) && (opts.fw > 3'd5));
  assign start     = trig && !exhausted && !bad;
  assign wb_step   = start && !opts.stat && !opts.ab;
  assign wb_clear  = start && !opts.stat && opts.ab;
  assign step      = busy && out_ready;
  assign last_i    = (i_cnt == acnt - CW'(1));
  assign last_j    = (j_cnt == narr - CW'(1));
  assign arr_end   = step && last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      pend   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      missed <= 1'b0;
      i_cnt  <= '0;
      j_cnt  <= '0;
      narr   <= '0;
    end else begin
      done <= 1'b0;
      if (ld_ok) begin
        err    <= 1'b0;
        missed <= 1'b0;
      end
      if (busy && evt) begin
        if (pend) missed <= 1'b1;
        else      pend   <= 1'b1;
      end else if (trig) begin
        pend <= pend && evt;
      end
      if (trig && !exhausted && bad) err <= 1'b1;
      if (start) begin
        busy  <= 1'b1;
        i_cnt <= '0;
        j_cnt <= '0;
        narr  <= opts.ab ? bcnt : CW'(1);
        if (opts.early) done <= 1'b1;
      end else if (step) begin
        if (last_i) begin
          i_cnt <= '0;
          if (last_j) begin
            busy <= 1'b0;
            if (!opts.early) done <= 1'b1;
          end else begin
            j_cnt <= j_cnt + CW'(1);
          end
        end else begin
          i_cnt <= i_cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/evt_addr_seq.sv
module evt_addr_seq
  import evt_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [OPT_W-1:0] cfg_opts,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CW-1:0]    cfg_acnt,
  input  logic [CW-1:0]    cfg_bcnt,
  input  logic [SW-1:0]    cfg_sstride,
  input  logic [SW-1:0]    cfg_dstride,
  input  logic             evt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_src,
  output logic [AW-1:0]    out_dst,
  output logic             done,
  output logic             err,
  output logic             missed,
  output logic             exhausted
);
  localparam int NSIDE = 2;

  opt_t          opts;
  logic [AW-1:0] src_b, dst_b, sstr_x, dstr_x;
  logic [CW-1:0] acnt, bcnt;
  logic          ld_ok, start, step, arr_end, wb_step, wb_clear;

  logic [AW-1:0] base_a [NSIDE];
  logic [AW-1:0] str_a  [NSIDE];
  logic [AW-1:0] addr_a [NSIDE];
  logic          cm_a   [NSIDE];

  evt_seq_pset #(.AW(AW), .CW(CW), .SW(SW)) u_pset (
    .clk(clk), .rst(rst), .ld(ld_ok), .ld_opts(opt_t'(cfg_opts)),
    .ld_src(cfg_src), .ld_dst(cfg_dst), .ld_acnt(cfg_acnt), .ld_bcnt(cfg_bcnt),
    .ld_sstr(cfg_sstride), .ld_dstr(cfg_dstride),
    .wb_step(wb_step), .wb_clear(wb_clear),
    .opts(opts), .src(src_b), .dst(dst_b), .acnt(acnt), .bcnt(bcnt),
    .sstr_x(sstr_x), .dstr_x(dstr_x)
  );

  evt_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .ld_req(cfg_load), .out_ready(out_ready),
    .opts(opts), .acnt(acnt), .bcnt(bcnt),
    .ld_ok(ld_ok), .start(start), .step(step), .arr_end(arr_end),
    .busy(out_valid), .done(done), .err(err), .missed(missed),
    .exhausted(exhausted), .wb_step(wb_step), .wb_clear(wb_clear)
  );

  assign base_a[0] = src_b;
  assign base_a[1] = dst_b;
  assign str_a[0]  = sstr_x;
  assign str_a[1]  = dstr_x;
  assign cm_a[0]   = opts.scon;
  assign cm_a[1]   = opts.dcon;

  for (genvar k = 0; k < NSIDE; k++) begin : g_side
    evt_seq_side #(.AW(AW)) u_side (
      .clk(clk), .rst(rst), .start(start), .step(step), .arr_end(arr_end),
      .cmode(cm_a[k]), .fwsel(opts.fw), .base(base_a[k]), .stride(str_a[k]),
      .addr(addr_a[k])
    );
  end

  assign out_src = addr_a[0];
  assign out_dst = addr_a[1];
endmodule

// File: rtl/evt_seq_chk.sv
module evt_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_load,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_src,
  input logic [AW-1:0] out_dst,
  input logic          done,
  input logic          err,
  input logic          missed,
  input logic          exhausted
);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_dst));

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !out_valid && !done);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> $past(cfg_load));

  p_exh_idle_r7: assert property (@(posedge clk) disable iff (rst)
    exhausted && !out_valid |=> !out_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_missed_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(missed) |-> $past(cfg_load));
endmodule

bind evt_addr_seq evt_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .out_valid(out_valid),
  .out_ready(out_ready), .out_src(out_src), .out_dst(out_dst), .done(done),
  .err(err), .missed(missed), .exhausted(exhausted)
);

// File: tb/evt_addr_seq_bench.sv
`timescale 1ns/1ps
module evt_addr_seq_bench;
  localparam int AW = 32, CW = 16, SW = 16;

  logic          clk = 0, rst = 1;
  logic          cfg_load = 0, evt = 0, out_ready = 0;
  logic [11:0]   cfg_opts = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_acnt = 0, cfg_bcnt = 0;
  logic [SW-1:0] cfg_sstride = 0, cfg_dstride = 0;
  logic          out_valid, done, err, missed, exhausted;
  logic [AW-1:0] out_src, out_dst;

  evt_addr_seq #(.AW(AW), .CW(CW), .SW(SW)) u_evt_addr_seq (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [AW-1:0] exp_s [0:1023];
  logic [AW-1:0] exp_d [0:1023];
  int wr = 0, rd = 0, done_cnt = 0, exp_done = 0;
  bit rnd_ready = 0;

  logic [11:0]   m_opts;
  logic [AW-1:0] m_s, m_d;
  int m_acnt, m_bcnt, m_ss, m_ds;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) if (rnd_ready) begin
    #1 out_ready = ($urandom % 4) != 0;
  end

  always @(negedge clk) if (!rst) begin
    if (out_valid && out_ready) begin
      if (rd >= wr) chk(0, "R1 R2 unexpected pair", out_src, 0);
      else begin
        chk(out_src == exp_s[rd], "R2 R3 R4 source address", out_src, exp_s[rd]);
        chk(out_dst == exp_d[rd], "R2 R3 R4 destination address", out_dst, exp_d[rd]);
        rd++;
      end
    end
    if (done) done_cnt++;
  end

  function automatic bit model_bad(input logic [11:0] o);
    return (o[7:4] != 0) || ((o[0] || o[1]) && o[10:8] > 5);
  endfunction

  // Accept one event into the model: expected pairs, done count, write-back.
  task automatic model_evt();
    int narr, fw;
    if (m_bcnt == 0 || model_bad(m_opts)) return;
    narr = m_opts[2] ? m_bcnt : 1;
    fw   = 1 << m_opts[10:8];
    for (int j = 0; j < narr; j++)
      for (int i = 0; i < m_acnt; i++) begin
        exp_s[wr] = m_s + AW'(j * m_ss + (m_opts[0] ? i % fw : i));
        exp_d[wr] = m_d + AW'(j * m_ds + (m_opts[1] ? i % fw : i));
        wr++;
      end
    exp_done++;
    if (!m_opts[3]) begin
      if (m_opts[2]) m_bcnt = 0;
      else begin
        m_bcnt--; m_s = m_s + AW'(m_ss); m_d = m_d + AW'(m_ds);
      end
    end
  endtask

  task automatic drive_cfg(input logic [11:0] o, input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input int a, input int b, input int ss, input int ds, input bit upd);
    @(posedge clk); #1;
    cfg_opts = o; cfg_src = s; cfg_dst = d; cfg_acnt = CW'(a); cfg_bcnt = CW'(b);
    cfg_sstride = SW'(ss); cfg_dstride = SW'(ds); cfg_load = 1;
    @(posedge clk); #1 cfg_load = 0;
    if (upd) begin
      m_opts = o; m_s = s; m_d = d; m_acnt = a; m_bcnt = b; m_ss = ss; m_ds = ds;
    end
  endtask

  task automatic pulse_evt();
    @(posedge clk); #1 evt = 1;
    @(posedge clk); #1 evt = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((rd != wr || out_valid) && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(rd == wr, {tag, " pair count"}, rd, wr);
    chk(done_cnt == exp_done, {tag, " R8 R9 done count"}, done_cnt, exp_done);
    rd = 0; wr = 0;
  endtask

  initial begin
    logic [AW-1:0] hs, hd;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid && !done && !err && !missed, "R10 reset outputs idle", out_valid, 0);
    chk(exhausted == 1, "R7 exhausted after reset", exhausted, 1);

    // R1 R3 R8: single array, counting upward, completion after last beat
    out_ready = 1;
    drive_cfg(12'h000, 32'h1000, 32'h2000, 3, 4, 'h40, -'h20, 1);
    model_evt();
    pulse_evt();
    @(negedge clk); chk(out_valid && !done, "R8 no early done", done, 0);
    @(negedge clk); @(negedge clk);
    @(negedge clk); chk(done && !out_valid, "R8 done after final beat", done, 1);
    @(negedge clk); chk(!done, "R8 done one cycle", done, 0);
    drain("R1");
    // second event uses written-back set (R6)
    rnd_ready = 1; model_evt(); pulse_evt(); drain("R6 write-back");
    rnd_ready = 0;

    // R10 hold while stalled
    #1 out_ready = 0;
    model_evt(); pulse_evt();
    @(negedge clk); hs = out_src; hd = out_dst;
    repeat (3) @(negedge clk);
    chk(out_valid && out_src == hs && out_dst == hd, "R10 stall hold", out_src, hs);
    @(posedge clk); #1 out_ready = 1;
    drain("R10");

    // R9 early completion, then R7 exhausted
    #1 out_ready = 0;
    drive_cfg(12'h800, 32'h3000, 32'h4000, 4, 1, 8, 8, 1);
    model_evt(); pulse_evt();
    @(negedge clk); chk(done && out_valid, "R9 done with first valid", done, 1);
    @(negedge clk); chk(!done, "R9 done one cycle", done, 0);
    @(posedge clk); #1 out_ready = 1;
    drain("R9");
    chk(exhausted == 1, "R7 exhausted at zero count", exhausted, 1);
    pulse_evt(); drain("R7 ignored event");

    // R2 R4: multi-array, source wraps in 4-byte window
    rnd_ready = 1;
    drive_cfg(12'h205, 32'h5000, 32'h6000, 10, 3, 'h100, 16, 1);
    model_evt(); pulse_evt(); drain("R2 R4");
    chk(exhausted == 1, "R6 multi-array clears count", exhausted, 1);

    // R6 static set: same addresses every event
    drive_cfg(12'h00A, 32'h7000, 32'h8000, 5, 1, 4, 4, 1);
    for (int k = 0; k < 3; k++) begin model_evt(); pulse_evt(); drain("R6 static"); end
    chk(exhausted == 0, "R6 static keeps count", exhausted, 0);

    // R5 rejection
    drive_cfg(12'h601, 32'h9000, 32'hA000, 4, 2, 4, 4, 1);
    model_evt(); pulse_evt(); drain("R5 reject");
    chk(err == 1, "R5 err set", err, 1);
    drive_cfg(12'h020, 32'h9000, 32'hA000, 4, 2, 4, 4, 1);
    chk(err == 0, "R12 load clears err", err, 0);
    model_evt(); pulse_evt(); drain("R5 reserved bits");
    chk(err == 1, "R5 reserved bits rejected", err, 1);
    drive_cfg(12'h700, 32'h9000, 32'hA000, 4, 2, 4, 4, 1);
    model_evt(); pulse_evt(); drain("R5 code ignored");
    chk(err == 0, "R5 code ignored when counting", err, 0);
    rnd_ready = 0;

    // R11 event on the final beat -> pending, not missed
    #1 out_ready = 1;
    drive_cfg(12'h000, 32'hB000, 32'hC000, 2, 5, 'h10, 'h20, 1);
    model_evt(); pulse_evt();
    model_evt();
    @(posedge clk); #1 evt = 1;
    @(posedge clk); #1 evt = 0;
    drain("R11 final-beat event");
    chk(missed == 0, "R11 no miss on final beat", missed, 0);

    // R11 overrun
    #1 out_ready = 0;
    drive_cfg(12'h000, 32'hD000, 32'hE000, 6, 5, 8, -8, 1);
    model_evt(); pulse_evt();
    model_evt(); pulse_evt();
    pulse_evt();
    @(negedge clk); chk(missed == 1, "R11 missed set", missed, 1);
    @(posedge clk); #1 out_ready = 1;
    drain("R11 pending order");
    chk(missed == 1, "R11 missed sticky", missed, 1);

    // R12 load rules
    drive_cfg(12'h000, 32'h1100, 32'h2200, 4, 5, 4, 4, 1);
    chk(missed == 0, "R12 load clears missed", missed, 0);
    #1 out_ready = 0;
    model_evt(); pulse_evt();
    drive_cfg(12'h000, 32'hFF00, 32'hEE00, 2, 9, 1, 1, 0);
    @(posedge clk); #1 out_ready = 1;
    drain("R12 busy load");
    model_evt(); pulse_evt(); drain("R12 load ignored while busy");
    @(posedge clk); #1;
    cfg_opts = 0; cfg_src = 32'h4400; cfg_dst = 32'h5500; cfg_acnt = 3; cfg_bcnt = 2;
    cfg_load = 1; evt = 1;
    @(posedge clk); #1 cfg_load = 0; evt = 0;
    m_opts = 0; m_s = 32'h4400; m_d = 32'h5500; m_acnt = 3; m_bcnt = 2; m_ss = 4; m_ds = 4;
    drain("R12 event in load cycle");
    model_evt(); pulse_evt(); drain("R12 load applied");

    // Random mix R1-R4, R6, R8, R9
    rnd_ready = 1;
    void'($urandom(32'd12345));
    for (int it = 0; it < 40; it++) begin
      logic [11:0] o;
      int ne;
      o = 12'($urandom % 16) & 12'h00F;
      o[10:8] = 3'($urandom % 6);
      o[11] = 1'($urandom % 2);
      drive_cfg(o, $urandom, $urandom, 1 + $urandom % 12, 1 + $urandom % 4,
                int'($urandom % 129) - 64, int'($urandom % 129) - 64, 1);
      ne = 1 + $urandom % 3;
      for (int e = 0; e < ne; e++) begin model_evt(); pulse_evt(); drain("R1 R2 R3 R4 random"); end
    end
    rnd_ready = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule